// File: doc/BRIEF.md
# Half-Word to Word Register Bridge

This block sits between a bus master that may issue byte, half-word or word accesses and a register file that accepts only full-width word accesses. Word accesses go straight through. Half-word accesses are reshaped by two holding registers, so that a pair of half-word accesses behaves like one word access.

A half-word write to the lower half of a word is parked in a write holding register and goes no further. The matching write to the upper half then produces one word write downstream, which carries both halves. A half-word read of the lower half reads the whole word downstream, returns its lower half and keeps the upper half in a read latch. The next read of the upper half is served from that latch, so the two halves come from the same instant. Byte accesses and the reserved size code are refused without touching the register file.

The downstream strobes are combinational in the request cycle. By default the upstream response (acknowledge, error and read data) is registered and appears one cycle after the request.

Top module: `half_word_bridge`

## Requirements
- R1: A half-word write (size code 01) with the half-select address bit (bit 1 for 32-bit data) at 0 raises neither rf_wen nor rf_ren. Its low 16 data bits (up_wdata[15:0]) are stored in the write holding register.
- R2: A half-word write with the half-select bit at 1 raises rf_wen for exactly that cycle. rf_wdata is {up_wdata[15:0], write holding register}, and rf_addr is up_addr with bits [1:0] cleared.
- R3: A half-word read with the half-select bit at 0 raises rf_ren. The response carries rf_rdata[15:0] in up_rdata[15:0] with the upper bits zero, and rf_rdata[31:16] is stored in the read latch.
- R4: A half-word read with the half-select bit at 1 raises no downstream strobe and returns the read latch in up_rdata[15:0] with the upper bits zero.
- R5: A word access (size code 10) raises rf_wen for a write, with rf_wdata equal to up_wdata, or rf_ren for a read, with up_rdata equal to rf_rdata.
- R6: A byte access (size code 00) or a reserved access (size code 11) raises no downstream strobe. Its response has up_err high for that single response cycle and up_rdata equal to 0.
- R7: Reset clears both holding registers. A first upper-half write therefore carries zero in its lower half, and a first upper-half read returns 0. up_ack and up_err are low after reset.
- R8: Every request is answered by up_ack exactly one cycle later. up_ack is low in cycles that follow no request. Write responses return up_rdata of 0.
- R9: Word accesses leave both the write holding register and the read latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_req | input | 1 | Upstream access request, one cycle per access |
| up_we | input | 1 | 1 for a write, 0 for a read |
| up_addr | input | ADDR_W | Byte address |
| up_size | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| up_wdata | input | DATA_W | Write data; a half-word uses the low half |
| up_ack | output | 1 | Response valid |
| up_err | output | 1 | Access refused because of its width |
| up_rdata | output | DATA_W | Read data; a half-word is returned in the low half |
| rf_wen | output | 1 | Register file word write strobe |
| rf_ren | output | 1 | Register file word read strobe |
| rf_addr | output | ADDR_W | Word-aligned register address |
| rf_wdata | output | DATA_W | Register file write data |
| rf_rdata | input | DATA_W | Register file read data, valid in the same cycle |

## Verification
A corrupted write holding register does not show up when it is loaded. It appears on rf_wdata[15:0] at the next upper-half write, however many accesses come in between. A stale or overwritten read latch is likewise hidden until the next upper-half read, where it shows in up_rdata one cycle after the request. The bench therefore mixes random word accesses between the two halves of each pair. It also reads upper halves after the word has been rewritten downstream, so that both holding registers can be seen to survive or snapshot correctly. A wrongly decoded size shows up at once, as a strobe in the request cycle or as an error flag one cycle later.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
   localparam logic [1:0] SZ_BYTE = 2'b00;
   localparam logic [1:0] SZ_HALF = 2'b01;
   localparam logic [1:0] SZ_WORD = 2'b10;

   typedef enum logic [2:0] {
      ACC_IDLE    = 3'd0,
      ACC_WORD    = 3'd1,
      ACC_HALF_LO = 3'd2,
      ACC_HALF_HI = 3'd3,
      ACC_BAD     = 3'd4
   } acc_kind_e;
endpackage

// File: rtl/hwb_decode.sv
module hwb_decode
   import hwb_pkg::*;
(
   input  logic       req_i,
   input  logic [1:0] size_i,
   input  logic       half_sel_i,
   output acc_kind_e  kind_o
);
   always_comb begin
      kind_o = ACC_IDLE;
      if (req_i) begin
         unique case (size_i)
            SZ_WORD: kind_o = ACC_WORD;
            SZ_HALF: kind_o = half_sel_i ? ACC_HALF_HI : ACC_HALF_LO;
            default: kind_o = ACC_BAD;
         endcase
      end
   end
endmodule

// File: rtl/hwb_write_merge.sv
module hwb_write_merge
   import hwb_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int HALF_W = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_kind_e         kind_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] merged_o
);
   logic [HALF_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (we_i && kind_i == ACC_HALF_LO)
         hold_q <= wdata_i[HALF_W-1:0];
   end

   always_comb begin
      if (kind_i == ACC_HALF_HI)
         merged_o = {wdata_i[HALF_W-1:0], hold_q};
      else
         merged_o = wdata_i;
   end

   assert_hold_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && kind_i == ACC_HALF_LO) |=> hold_q == $past(wdata_i[HALF_W-1:0]));

   assert_word_keeps_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == ACC_WORD) |=> $stable(hold_q));
endmodule

// File: rtl/hwb_read_split.sv
module hwb_read_split
   import hwb_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int HALF_W = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_kind_e         kind_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] rf_rdata_i,
   output logic [DATA_W-1:0] resp_o
);
   logic [HALF_W-1:0] latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         latch_q <= '0;
      else if (!we_i && kind_i == ACC_HALF_LO)
         latch_q <= rf_rdata_i[DATA_W-1:HALF_W];
   end

   always_comb begin
      resp_o = '0;
      if (!we_i) begin
         unique case (kind_i)
            ACC_WORD:    resp_o = rf_rdata_i;
            ACC_HALF_LO: resp_o = {{HALF_W{1'b0}}, rf_rdata_i[HALF_W-1:0]};
            ACC_HALF_HI: resp_o = {{HALF_W{1'b0}}, latch_q};
            default:     resp_o = '0;
         endcase
      end
   end

   assert_latch_snapshot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_i && kind_i == ACC_HALF_LO) |=> latch_q == $past(rf_rdata_i[DATA_W-1:HALF_W]));

   assert_word_keeps_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == ACC_WORD) |=> $stable(latch_q));
endmodule

// File: rtl/half_word_bridge.sv
module half_word_bridge
   import hwb_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter bit RESP_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_req,
   input  logic              up_we,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [1:0]        up_size,
   input  logic [DATA_W-1:0] up_wdata,
   output logic              up_ack,
   output logic              up_err,
   output logic [DATA_W-1:0] up_rdata,
   output logic              rf_wen,
   output logic              rf_ren,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_wdata,
   input  logic [DATA_W-1:0] rf_rdata
);
   localparam int HALF_W   = DATA_W / 2;
   localparam int LANE_LSB = $clog2(DATA_W / 8);
   localparam int SEL_BIT  = LANE_LSB - 1;

   initial begin
      assert (DATA_W == 32 || DATA_W == 64)
         else $error("half_word_bridge: DATA_W must be 32 or 64");
      assert (ADDR_W > LANE_LSB)
         else $error("half_word_bridge: ADDR_W too small for DATA_W");
   end

   acc_kind_e         kind;
   logic [DATA_W-1:0] resp_data;
   logic              unused_addr_bits;

   assign unused_addr_bits = ^up_addr[SEL_BIT:0];

   hwb_decode u_decode (
      .req_i      (up_req),
      .size_i     (up_size),
      .half_sel_i (up_addr[SEL_BIT]),
      .kind_o     (kind)
   );

   hwb_write_merge #(.DATA_W(DATA_W)) u_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind_i   (kind),
      .we_i     (up_we),
      .wdata_i  (up_wdata),
      .merged_o (rf_wdata)
   );

   hwb_read_split #(.DATA_W(DATA_W)) u_split (
      .clk        (clk),
      .rst_n      (rst_n),
      .kind_i     (kind),
      .we_i       (up_we),
      .rf_rdata_i (rf_rdata),
      .resp_o     (resp_data)
   );

   assign rf_wen  = up_we  && (kind == ACC_WORD || kind == ACC_HALF_HI);
   assign rf_ren  = !up_we && (kind == ACC_WORD || kind == ACC_HALF_LO);
   assign rf_addr = {up_addr[ADDR_W-1:LANE_LSB], {LANE_LSB{1'b0}}};

   generate
      if (RESP_REG) begin : g_resp_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               up_ack   <= 1'b0;
               up_err   <= 1'b0;
               up_rdata <= '0;
            end else begin
               up_ack   <= up_req;
               up_err   <= (kind == ACC_BAD);
               up_rdata <= resp_data;
            end
         end

         assert_ack_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
            up_req |=> up_ack);

         assert_no_spurious_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !up_req |=> !up_ack);

         assert_err_zero_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
            up_err |-> (up_ack && up_rdata == '0));
      end else begin : g_resp_comb
         assign up_ack   = up_req;
         assign up_err   = (kind == ACC_BAD);
         assign up_rdata = resp_data;
      end
   endgenerate

   assert_lo_write_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req && up_we && up_size == SZ_HALF && !up_addr[SEL_BIT]) |-> !(rf_wen || rf_ren));

   assert_hi_write_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req && up_we && up_size == SZ_HALF && up_addr[SEL_BIT])
         |-> (rf_wen && rf_wdata[DATA_W-1:HALF_W] == up_wdata[HALF_W-1:0]));

   assert_hi_read_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req && !up_we && up_size == SZ_HALF && up_addr[SEL_BIT]) |-> !(rf_wen || rf_ren));

   assert_bad_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req && (up_size == SZ_BYTE || up_size == 2'b11)) |-> !(rf_wen || rf_ren));

   assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rf_wen && rf_ren));
endmodule

// File: tb/sim_half_word_bridge.sv
module sim_half_word_bridge;
   localparam int AW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          up_req = 1'b0;
   logic          up_we = 1'b0;
   logic [AW-1:0] up_addr = '0;
   logic [1:0]    up_size = 2'b10;
   logic [DW-1:0] up_wdata = '0;
   logic          up_ack, up_err, rf_wen, rf_ren;
   logic [DW-1:0] up_rdata, rf_wdata, rf_rdata;
   logic [AW-1:0] rf_addr;

   logic [DW-1:0] mem [0:63];
   logic [DW-1:0] exp_mem [0:63];
   logic [15:0]   m_hold, m_latch;
   int            checks = 0;
   int            errors = 0;

   always #2 clk = ~clk;

   half_word_bridge #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_we(up_we), .up_addr(up_addr),
      .up_size(up_size), .up_wdata(up_wdata), .up_ack(up_ack), .up_err(up_err),
      .up_rdata(up_rdata), .rf_wen(rf_wen), .rf_ren(rf_ren), .rf_addr(rf_addr),
      .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
   );

   assign rf_rdata = mem[rf_addr[7:2]];
   always @(posedge clk) if (rf_wen) mem[rf_addr[7:2]] <= rf_wdata;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic txn(input bit we, input logic [1:0] size, input logic [AW-1:0] addr,
                      input logic [DW-1:0] wdata);
      bit            e_wen = 0, e_ren = 0, e_err = 0;
      logic [DW-1:0] e_wd = '0, e_rd = '0;
      string         tag;
      int            idx = int'(addr[7:2]);
      tag = "R5";
      if (size == 2'b01) begin
         if (we && !addr[1]) begin tag = "R1"; m_hold = wdata[15:0]; end
         else if (we) begin
            tag = "R2"; e_wen = 1; e_wd = {wdata[15:0], m_hold}; exp_mem[idx] = e_wd;
         end else if (!addr[1]) begin
            tag = "R3"; e_ren = 1; e_rd = {16'h0, exp_mem[idx][15:0]}; m_latch = exp_mem[idx][31:16];
         end else begin
            tag = "R4"; e_rd = {16'h0, m_latch};
         end
      end else if (size == 2'b10) begin
         if (we) begin e_wen = 1; e_wd = wdata; exp_mem[idx] = wdata; end
         else begin e_ren = 1; e_rd = exp_mem[idx]; end
      end else begin
         tag = "R6"; e_err = 1;
      end
      @(negedge clk);
      up_req = 1; up_we = we; up_size = size; up_addr = addr; up_wdata = wdata;
      #1;
      chk(rf_wen == e_wen, {tag, " wen"}, 64'(rf_wen), 64'(e_wen));
      chk(rf_ren == e_ren, {tag, " ren"}, 64'(rf_ren), 64'(e_ren));
      if (e_wen) chk(rf_wdata == e_wd, {tag, " wdata"}, 64'(rf_wdata), 64'(e_wd));
      if (e_wen || e_ren)
         chk(rf_addr == {addr[7:2], 2'b00}, {tag, " addr"}, 64'(rf_addr), 64'({addr[7:2], 2'b00}));
      @(negedge clk);
      up_req = 0;
      chk(up_ack == 1'b1, "R8 ack", 64'(up_ack), 64'd1);
      chk(up_err == e_err, {tag, " err"}, 64'(up_err), 64'(e_err));
      chk(up_rdata == e_rd, {tag, " rdata"}, 64'(up_rdata), 64'(e_rd));
      @(negedge clk);
      chk(up_ack == 1'b0, "R8 idle ack", 64'(up_ack), 64'd0);
      chk(up_err == 1'b0, "R6 err pulse", 64'(up_err), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      void'($urandom(32'h1f2e3d4c));
      m_hold = '0; m_latch = '0;
      for (int i = 0; i < 64; i++) begin
         mem[i] = 32'hA5000000 ^ (i * 32'h01030507);
         exp_mem[i] = mem[i];
      end
      repeat (3) @(negedge clk);
      chk(up_ack == 0, "R7 reset ack", 64'(up_ack), 0);
      chk(up_err == 0, "R7 reset err", 64'(up_err), 0);
      chk(rf_wen == 0 && rf_ren == 0, "R7 reset strobes", 64'({rf_wen, rf_ren}), 0);
      rst_n = 1;
      // R7: latch and hold start at zero
      txn(0, 2'b01, 8'h06, '0);
      txn(1, 2'b01, 8'h0A, 32'h0000BEEF);
      // R1/R2 pair
      txn(1, 2'b01, 8'h10, 32'hFFFF1234);
      txn(1, 2'b01, 8'h12, 32'h0000ABCD);
      txn(0, 2'b10, 8'h10, '0);
      // R9: word access between halves keeps hold
      txn(1, 2'b01, 8'h20, 32'h00005555);
      txn(1, 2'b10, 8'h24, 32'hCAFEF00D);
      txn(0, 2'b10, 8'h28, '0);
      txn(1, 2'b01, 8'h22, 32'h00006666);
      // R3/R4 atomic snapshot across a rewrite
      txn(0, 2'b01, 8'h30, '0);
      txn(1, 2'b10, 8'h30, 32'h11112222);
      txn(0, 2'b10, 8'h34, '0);
      txn(0, 2'b01, 8'h32, '0);
      // R6 byte and reserved sizes
      txn(1, 2'b00, 8'h41, 32'hFFFFFFFF);
      txn(0, 2'b00, 8'h43, '0);
      txn(1, 2'b11, 8'h44, 32'h12345678);
      txn(0, 2'b11, 8'h46, '0);
      txn(0, 2'b10, 8'h40, '0);
      for (int n = 0; n < 800; n++) begin
         logic [1:0] sz;
         int r = int'($urandom % 10);
         sz = (r < 4) ? 2'b01 : (r < 8) ? 2'b10 : (r == 8) ? 2'b00 : 2'b11;
         txn(1'($urandom), sz, 8'($urandom % 16) | 8'h60 ^ 8'($urandom % 4 * 4), $urandom);
      end
      for (int i = 0; i < 64; i++) txn(0, 2'b10, 8'(i * 4), '0);
      summary();
   end
endmodule